// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the slave side of an asynchronous host register bus. The bus has an 8-bit data path and a separate 10-bit address path, so it reaches 1024 locations; address and data never share pins. A two-bit mode input chooses how the bus control pins are read. In split-strobe mode there is one active-low read strobe and one active-low write strobe. In single-strobe mode one active-low data strobe marks the cycle, and a direction level picks read or write. The mode can change at run time, and both styles use the same pins.

Every control input and the mode input go through a two-flop synchroniser into the system clock domain. The start of each qualified bus cycle makes exactly one single-cycle internal request. A read request comes with its address. A write request comes with the address and the data captured at that same moment. For test, a small register file sits behind the port. The port drives read data back out with an output enable, and the enable is set only during an active read.

Top module: `hostbus_port`

## Requirements
- R1: With mode 2'b00, a low level on `rd_n` while `cs_n` is low is one read cycle, and a low level on `wr_n` while `cs_n` is low is one write cycle. In this mode `ds_n` and `rw` have no effect.
- R2: With mode 2'b01, a low level on `ds_n` while `cs_n` is low is a read when `rw` is 1 and a write when `rw` is 0. In this mode `rd_n` and `wr_n` have no effect.
- R3: Modes 2'b10 and 2'b11 give no access: no request, no register change and no output enable.
- R4: While `cs_n` is high no access of any kind takes place, whatever the strobes do.
- R5: Each bus cycle makes exactly one `req_rd` or `req_wr` pulse that lasts one clock. Read and write requests are never high together.
- R6: A write request shows the `addr` and `wdata` values present at the start of the strobe. The same pulse commits them, so a mapped register holds the new value and a later read returns it.
- R7: `rdata_oe` is high only while chip select and the read qualifier are both active. During a read, `rdata` holds the addressed value while `rdata_oe` is high. `rdata_oe` falls within four clocks of the read strobe ending, even when `cs_n` stays low.
- R8: The test register file has 8 registers at addresses 0x040 to 0x047. Every other address reads back 0x00, and writes to those addresses change no register. A write request is still issued for them.
- R9: After reset, `rdata` is 0x00, `rdata_oe` is 0, no request is issued, and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bus timing style: 00 split strobes, 01 single strobe, others reserved |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (split mode) |
| wr_n | input | 1 | Active-low write strobe (split mode) |
| ds_n | input | 1 | Active-low data strobe (single-strobe mode) |
| rw | input | 1 | Direction level, 1 read, 0 write (single-strobe mode) |
| addr | input | 10 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| rdata_oe | output | 1 | Output enable for the read data drivers |
| req_rd | output | 1 | One-clock internal read request |
| req_wr | output | 1 | One-clock internal write request |
| req_addr | output | 10 | Address of the current request |
| req_wdata | output | 8 | Write data of the current write request |

## Verification
The hardest case is a strobe that is active on its own pins but is not valid for the current mode. Examples are a data-strobe pulse in split mode, a read or write strobe in single-strobe mode, any strobe in a reserved mode, and any strobe with chip select high. None of these may leave a trace at the ports. The bench drives every strobe style under every mode value and with chip select both on and off. It then counts request pulses and reads back all eight registers to show that nothing changed. A full sweep over all 1024 addresses then compares each read with a value the bench computes from the write pattern and the mapped window.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'b00,
    MODE_SINGLE  = 2'b01,
    MODE_RSV_A   = 2'b10,
    MODE_RSV_B   = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic ds_n;
    logic rw;
  } bus_ctl_t;

  localparam int CTL_W = $bits(bus_ctl_t);

  // Address window membership, done in 32-bit arithmetic
  function automatic logic in_window(input int a, input int base, input int n);
    return (a >= base) && (a < base + n);
  endfunction

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int                W       = 1,
  parameter int                STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_s,
  input  bus_ctl_t          ctl_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_act,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              req_rd,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);

  logic wr_act;
  logic any_act;
  logic act_q;
  logic cycle_start;
  bus_mode_e mode_e;

  assign mode_e = bus_mode_e'(mode_s);

  always_comb begin
    rd_act = 1'b0;
    wr_act = 1'b0;
    case (mode_e)
      MODE_SPLIT: begin
        rd_act = !ctl_s.cs_n && !ctl_s.rd_n;
        wr_act = !ctl_s.cs_n && !ctl_s.wr_n;
      end
      MODE_SINGLE: begin
        rd_act = !ctl_s.cs_n && !ctl_s.ds_n &&  ctl_s.rw;
        wr_act = !ctl_s.cs_n && !ctl_s.ds_n && !ctl_s.rw;
      end
      default: begin
        rd_act = 1'b0;
        wr_act = 1'b0;
      end
    endcase
  end

  assign any_act     = rd_act || wr_act;
  assign cycle_start = any_act && !act_q;
  assign rd_fire     = cycle_start && rd_act;
  assign wr_fire     = cycle_start && wr_act && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      req_rd    <= 1'b0;
      req_wr    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      act_q  <= any_act;
      req_rd <= rd_fire;
      req_wr <= wr_fire;
      if (cycle_start) begin
        req_addr  <= addr;
        req_wdata <= wdata;
      end
    end
  end

  assert_one_pulse_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> !req_rd);
  assert_one_pulse_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> !req_wr);
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && req_wr));
  assert_reserved_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s[1] |=> !req_rd && !req_wr);
  assert_cs_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.cs_n |=> !req_rd && !req_wr);
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> req_addr == $past(addr) && req_wdata == $past(wdata));

endmodule

// File: rtl/hbp_regfile.sv
module hbp_regfile
  import hbp_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                DATA_W   = 8,
  parameter int                NREGS    = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 10'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0][DATA_W-1:0] regs;
  logic [ADDR_W-1:0] wdiff, rdiff;
  logic [IDX_W-1:0]  widx, ridx;
  logic              whit, rhit;

  assign wdiff = wr_addr - REG_BASE;
  assign rdiff = rd_addr - REG_BASE;
  assign widx  = wdiff[IDX_W-1:0];
  assign ridx  = rdiff[IDX_W-1:0];
  assign whit  = in_window(int'(wr_addr), int'(REG_BASE), NREGS);
  assign rhit  = in_window(int'(rd_addr), int'(REG_BASE), NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en && whit) begin
      regs[widx] <= wr_data;
    end
  end

  assign rd_data = rhit ? regs[ridx] : '0;

  assert_unmapped_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !whit) |=> $stable(regs));
  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && whit) |=> regs[$past(widx)] == $past(wr_data));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hbp_pkg::*;
#(
  parameter int                ADDR_W      = 10,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                NREGS       = 8,
  parameter logic [ADDR_W-1:0] REG_BASE    = 10'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              req_rd,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);

  bus_ctl_t          ctl_raw, ctl_s;
  logic [CTL_W-1:0]  ctl_q;
  logic [1:0]        mode_s;
  logic              rd_act, rd_fire, wr_fire;
  logic [DATA_W-1:0] rf_rdata;

  assign ctl_raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, ds_n: ds_n, rw: rw};

  hbp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q)
  );
  assign ctl_s = bus_ctl_t'(ctl_q);

  hbp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_mode (
    .clk(clk), .rst_n(rst_n), .d(mode), .q(mode_s)
  );

  hbp_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .ctl_s(ctl_s),
    .addr(addr), .wdata(wdata),
    .rd_act(rd_act), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata)
  );

  hbp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_wr), .wr_addr(req_addr), .wr_data(req_wdata),
    .rd_addr(addr), .rd_data(rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd_act;
      if (rd_fire) rdata <= rf_rdata;
    end
  end

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(!ctl_s.cs_n) && !req_wr);
  assert_oe_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_s[1]) |-> !rdata_oe);
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));

endmodule

// File: tb/test_hostbus_port.sv
module test_hostbus_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe, req_rd, req_wr;
  logic [9:0] req_addr;
  logic [7:0] req_wdata;

  int checks = 0;
  int errors = 0;
  int n_rd = 0, n_wr = 0;
  logic [9:0] last_a;
  logic [7:0] last_d;
  logic [7:0] model [8];

  localparam int BASE = 'h040;

  always #4 clk = ~clk;

  hostbus_port i_hostbus_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ds_n(ds_n), .rw(rw), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata)
  );

  always @(negedge clk) begin
    if (rst_n && req_wr) begin n_wr++; last_a = req_addr; last_d = req_wdata; end
    if (rst_n && req_rd) n_rd++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 rd_n, 1 wr_n, 2 ds_n with rw=1, 3 ds_n with rw=0
  task automatic bus_op(input logic [1:0] m, input int sel, input logic [9:0] a,
                        input logic [7:0] d, input bit cs_on,
                        output logic [7:0] rd_val, output bit oe_mid, output bit oe_end);
    @(negedge clk);
    if (mode !== m) begin mode = m; idle(4); end
    addr = a; wdata = d; rw = (sel == 3) ? 1'b0 : 1'b1;
    cs_n = !cs_on;
    idle(3);
    case (sel)
      0: rd_n = 1'b0;
      1: wr_n = 1'b0;
      default: ds_n = 1'b0;
    endcase
    idle(5);
    rd_val = rdata; oe_mid = rdata_oe;
    rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1;
    idle(4);
    oe_end = rdata_oe;
    cs_n = 1'b1; rw = 1'b1;
    idle(3);
  endtask

  function automatic logic [7:0] expect_at(input int a);
    if (a >= BASE && a < BASE + 8) return model[a - BASE];
    return 8'h00;
  endfunction

  task automatic read_all(input logic [1:0] m, input int sel, input string tag);
    logic [7:0] v; bit om, oe;
    for (int i = 0; i < 8; i++) begin
      bus_op(m, sel, 10'(BASE + i), 8'h00, 1'b1, v, om, oe);
      chk(v == model[i] && om, tag, v, model[i]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v; bit om, oe;
    int w0, r0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R9 reset state
    chk(rdata == 8'h00, "R9 rdata", rdata, 0);
    chk(rdata_oe == 1'b0, "R9 oe", rdata_oe, 0);
    chk(n_rd == 0 && n_wr == 0, "R9 no req", n_rd + n_wr, 0);
    read_all(2'b00, 0, "R9 reg reset");

    // R1 split strobes: write and read back, R5/R6 on each write
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d = 8'((i * 37) ^ 8'hA5);
      w0 = n_wr; r0 = n_rd;
      bus_op(2'b00, 1, 10'(BASE + i), d, 1'b1, v, om, oe);
      model[i] = d;
      chk(n_wr == w0 + 1 && n_rd == r0, "R5 one write pulse", n_wr - w0, 1);
      chk(last_a == 10'(BASE + i) && last_d == d, "R6 captured", last_d, d);
      chk(!om, "R7 no oe on write", om, 0);
    end
    for (int i = 0; i < 8; i++) begin
      r0 = n_rd;
      bus_op(2'b00, 0, 10'(BASE + i), 8'h00, 1'b1, v, om, oe);
      chk(v == model[i], "R1 split read", v, model[i]);
      chk(om && !oe, "R7 oe window", {om, oe}, 2'b10);
      chk(n_rd == r0 + 1, "R5 one read pulse", n_rd - r0, 1);
    end

    // R2 single strobe with direction level
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d = 8'((i * 91 + 3) ^ 8'h3C);
      w0 = n_wr;
      bus_op(2'b01, 3, 10'(BASE + i), d, 1'b1, v, om, oe);
      model[i] = d;
      chk(n_wr == w0 + 1, "R2 single write", n_wr - w0, 1);
    end
    read_all(2'b01, 2, "R2 single read");

    // R1: ds_n ignored in split mode; R2: rd_n/wr_n ignored in single mode
    w0 = n_wr; r0 = n_rd;
    bus_op(2'b00, 2, 10'(BASE), 8'hFF, 1'b1, v, om, oe);
    bus_op(2'b00, 3, 10'(BASE + 1), 8'hFF, 1'b1, v, om, oe);
    chk(n_wr == w0 && n_rd == r0 && !om, "R1 ds ignored", n_wr + n_rd - w0 - r0, 0);
    bus_op(2'b01, 0, 10'(BASE + 2), 8'hFF, 1'b1, v, om, oe);
    bus_op(2'b01, 1, 10'(BASE + 3), 8'hFF, 1'b1, v, om, oe);
    chk(n_wr == w0 && n_rd == r0 && !om, "R2 rd/wr ignored", n_wr + n_rd - w0 - r0, 0);

    // R3 reserved modes, every strobe style
    for (int m = 2; m < 4; m++)
      for (int s = 0; s < 4; s++) begin
        w0 = n_wr; r0 = n_rd;
        bus_op(2'(m), s, 10'(BASE + s), 8'hEE, 1'b1, v, om, oe);
        chk(n_wr == w0 && n_rd == r0 && !om, "R3 reserved no access",
            n_wr + n_rd - w0 - r0, 0);
      end

    // R4 chip select high
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        w0 = n_wr; r0 = n_rd;
        bus_op(2'(m), s, 10'(BASE + 4 + s), 8'h11, 1'b0, v, om, oe);
        chk(n_wr == w0 && n_rd == r0 && !om, "R4 cs gate", n_wr + n_rd - w0 - r0, 0);
      end
    read_all(2'b00, 0, "R3 R4 regs unchanged");

    // R8 unmapped writes: request issued, no register change
    begin
      int ua [4] = '{0, 'h03F, 'h048, 'h3FF};
      foreach (ua[k]) begin
        w0 = n_wr;
        bus_op(2'b00, 1, 10'(ua[k]), 8'h5A, 1'b1, v, om, oe);
        chk(n_wr == w0 + 1, "R8 unmapped write request", n_wr - w0, 1);
      end
    end
    read_all(2'b00, 0, "R8 regs unchanged");

    // R8 / R1 sweep of the whole address space
    for (int a = 0; a < 1024; a++) begin
      bus_op(2'b00, 0, 10'(a), 8'h00, 1'b1, v, om, oe);
      chk(v == expect_at(a) && om, "R8 sweep read", v, expect_at(a));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule